// File: doc/BRIEF.md
# Address-Snooping ROM Bank Selector

This block listens to the address bus of an 8-bit processor and decides which bank of the main system ROM and which bank of the character-generator ROM are in use. It never looks at data. It is set up only by which addresses the processor touches, and both reads and writes count. Addresses below 0xC080 are ignored entirely.

Setup mode is the state in which the system bank equals 0. To enter it, the processor touches a fixed three-address unlock sequence. While in setup mode, touching either of two 16-byte windows loads a 4-bit bank number from the low address nibble. A few fixed addresses answer reads with status or identification bytes. For those reads, an override enable and an override byte tell the surrounding memory decode to replace the ROM data. Writes always reach memory.

Top module: `rom_bank_snoop`

## Requirements
- R1: After reset both bank outputs are 0, the unlock tracker is at its first step and, because the system bank is 0, the block is in setup mode.
- R2: An access with an address below 0xC080 changes no bank, never raises the override enable and leaves the unlock tracker where it was.
- R3: Outside setup mode, valid accesses to 0xCACA, 0xCACA and 0xCAFE, in that order, set the system bank to 0 on the clock edge that ends the 0xCAFE access. They also return the tracker to its first step.
- R4: Outside setup mode, an examined access that is not the next expected sequence address returns the tracker to its first step. A third 0xCACA after two matched steps therefore does not count as step one.
- R5: The unlock tracker does not advance while in setup mode.
- R6: In setup mode, a read or write to 0xCEF0 through 0xCEFF sets the system bank to address bits [3:0] at the edge ending the access.
- R7: In setup mode, a read or write to 0xCFD0 through 0xCFDF sets the text bank to address bits [3:0]. Outside setup mode these windows have no effect.
- R8: In setup mode, a read of 0xD034 raises the override enable with byte 0xE0 plus the system bank. A read of 0xD02E raises it with byte 0xD0 plus the text bank.
- R9: In setup mode, reads of 0xDFFE and 0xDFFF raise the override enable with bytes 0x4A and 0xCD.
- R10: The override enable is low for every write and for every read made outside setup mode.
- R11: Cycles without a valid strobe change neither bank nor the unlock tracker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe marking a bus access |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_addr | input | 16 | Access address |
| sys_bank | output | 4 | Selected system ROM bank |
| txt_bank | output | 4 | Selected character ROM bank |
| ovr_en | output | 1 | Replace memory read data with ovr_data (combinational) |
| ovr_data | output | 8 | Replacement read byte |

## Verification
The bench runs the clean unlock sequence and then several broken variants. These are: three 0xCACA accesses before 0xCAFE, a foreign examined address inserted mid-sequence, a low address inserted mid-sequence, and idle gaps between steps. Together they separate a tracker that restarts correctly from one that restarts on the wrong step, one that counts unexamined addresses, and one that counts idle cycles. Bank windows are hit with both reads and writes, both inside and outside setup mode. Read-back addresses are read and written in both modes, which separates mode gating from read/write gating.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int ADDR_W = 16;

  // lowest address the snooper examines
  localparam logic [ADDR_W-1:0] LOW_LIMIT   = 16'hC080;

  // unlock sequence, in order
  localparam int SEQ_LEN = 3;
  localparam logic [ADDR_W-1:0] SEQ_ADDR [SEQ_LEN] = '{16'hCACA, 16'hCACA, 16'hCAFE};

  // bank-load windows (upper 12 bits compared)
  localparam logic [ADDR_W-1:0] SYS_WIN     = 16'hCEF0;
  localparam logic [ADDR_W-1:0] TXT_WIN     = 16'hCFD0;

  // read-back addresses and tags
  localparam logic [ADDR_W-1:0] SYS_RB_ADDR = 16'hD034;
  localparam logic [ADDR_W-1:0] TXT_RB_ADDR = 16'hD02E;
  localparam logic [ADDR_W-1:0] ID0_ADDR    = 16'hDFFE;
  localparam logic [ADDR_W-1:0] ID1_ADDR    = 16'hDFFF;
  localparam logic [7:0] SYS_TAG = 8'hE0;
  localparam logic [7:0] TXT_TAG = 8'hD0;
  localparam logic [7:0] ID0_VAL = 8'h4A;
  localparam logic [7:0] ID1_VAL = 8'hCD;
endpackage

// File: rtl/rbs_unlock.sv
module rbs_unlock
  import rbs_pkg::*;
#(
  parameter int N_STEPS = SEQ_LEN,
  localparam int STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1,
  localparam int SLOTS  = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exam,
  input  logic              setup,
  input  logic [ADDR_W-1:0] addr,
  output logic              unlock_hit
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic [STEP_W-1:0] step;
  logic [SLOTS-1:0]  match;
  logic              cur_match;
  logic              track;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_cmp
      if (gi < N_STEPS) begin : g_real
        assign match[gi] = (addr == SEQ_ADDR[gi]);
      end else begin : g_pad
        assign match[gi] = 1'b0;
      end
    end
  endgenerate

  assign cur_match  = match[step];
  assign track      = exam && !setup;
  assign unlock_hit = track && cur_match && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (track) begin
      if (!cur_match || step == LAST) step <= '0;
      else                            step <= step + 1'b1;
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(step) < N_STEPS); // R4
  AST_MISS_RESTART: assert property (@(posedge clk) disable iff (rst)
    (track && !cur_match) |=> (step == '0)); // R4
  AST_SETUP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (exam && setup) |=> $stable(step)); // R5
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !exam |=> $stable(step)); // R11
endmodule

// File: rtl/rbs_bank_regs.sv
module rbs_bank_regs
  import rbs_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exam,
  input  logic              setup,
  input  logic              unlock_hit,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] sys_bank,
  output logic [BANK_W-1:0] txt_bank
);
  logic sys_win, txt_win;

  assign sys_win = (addr[ADDR_W-1:BANK_W] == SYS_WIN[ADDR_W-1:BANK_W]);
  assign txt_win = (addr[ADDR_W-1:BANK_W] == TXT_WIN[ADDR_W-1:BANK_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_bank <= '0;
      txt_bank <= '0;
    end else if (unlock_hit) begin
      sys_bank <= '0;
    end else if (exam && setup) begin
      if (sys_win)      sys_bank <= addr[BANK_W-1:0];
      else if (txt_win) txt_bank <= addr[BANK_W-1:0];
    end
  end

  AST_UNLOCK_SETUP: assert property (@(posedge clk) disable iff (rst)
    unlock_hit |=> (sys_bank == '0)); // R3
  AST_TXT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (sys_bank != '0) |=> $stable(txt_bank)); // R7
  AST_SYS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (exam && setup && sys_win) |=> (sys_bank == $past(addr[BANK_W-1:0]))); // R6
endmodule

// File: rtl/rbs_readback.sv
module rbs_readback
  import rbs_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              exam,
  input  logic              rd,
  input  logic              setup,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] sys_bank,
  input  logic [BANK_W-1:0] txt_bank,
  output logic              ovr_en,
  output logic [DATA_W-1:0] ovr_data
);
  logic hit;

  always_comb begin
    hit      = 1'b1;
    ovr_data = '0;
    unique case (addr)
      SYS_RB_ADDR: ovr_data = DATA_W'(SYS_TAG) + DATA_W'(sys_bank);
      TXT_RB_ADDR: ovr_data = DATA_W'(TXT_TAG) + DATA_W'(txt_bank);
      ID0_ADDR:    ovr_data = DATA_W'(ID0_VAL);
      ID1_ADDR:    ovr_data = DATA_W'(ID1_VAL);
      default:     hit      = 1'b0;
    endcase
    ovr_en = exam && rd && setup && hit;
  end
endmodule

// File: rtl/rom_bank_snoop.sv
module rom_bank_snoop
  import rbs_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_rd,
  input  logic [15:0]       acc_addr,
  output logic [BANK_W-1:0] sys_bank,
  output logic [BANK_W-1:0] txt_bank,
  output logic              ovr_en,
  output logic [DATA_W-1:0] ovr_data
);
  logic exam, setup, unlock_hit;

  assign exam  = acc_valid && (acc_addr >= LOW_LIMIT);
  assign setup = (sys_bank == '0);

  rbs_unlock #(.N_STEPS(SEQ_LEN)) u_unlock (
    .clk(clk), .rst(rst), .exam(exam), .setup(setup),
    .addr(acc_addr), .unlock_hit(unlock_hit)
  );

  rbs_bank_regs #(.BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst(rst), .exam(exam), .setup(setup),
    .unlock_hit(unlock_hit), .addr(acc_addr),
    .sys_bank(sys_bank), .txt_bank(txt_bank)
  );

  rbs_readback #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_rb (
    .exam(exam), .rd(acc_rd), .setup(setup), .addr(acc_addr),
    .sys_bank(sys_bank), .txt_bank(txt_bank),
    .ovr_en(ovr_en), .ovr_data(ovr_data)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sys_bank == '0 && txt_bank == '0)); // R1
  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (acc_addr < LOW_LIMIT) |-> !ovr_en); // R2
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr < LOW_LIMIT) |=> ($stable(sys_bank) && $stable(txt_bank))); // R2
  AST_WR_NO_OVR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_rd) |-> !ovr_en); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ($stable(sys_bank) && $stable(txt_bank))); // R11
  AST_ID_BYTES: assert property (@(posedge clk) disable iff (rst)
    (ovr_en && acc_addr == ID0_ADDR) |-> (ovr_data == DATA_W'(ID0_VAL))); // R9
endmodule

// File: tb/rom_bank_snoop_tb.sv
module rom_bank_snoop_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_rd = 1'b1;
  logic [15:0] acc_addr = 16'h0000;
  logic [3:0]  sys_bank, txt_bank;
  logic        ovr_en;
  logic [7:0]  ovr_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_sys = 0, m_txt = 0, m_step = 0;
  int seq_q[$] = '{'hCACA, 'hCACA, 'hCAFE};

  always #4 clk = ~clk;

  rom_bank_snoop dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .sys_bank(sys_bank), .txt_bank(txt_bank),
    .ovr_en(ovr_en), .ovr_data(ovr_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_banks(input string req);
    check(req, "sys_bank", int'(sys_bank), m_sys);
    check(req, "txt_bank", int'(txt_bank), m_txt);
  endtask

  // one access of one cycle, compared against the model
  task automatic access(input int a, input bit rd, input string req);
    bit exam, setup, hit;
    int exp_d;
    exam = (a >= 'hC080);
    setup = (m_sys == 0);
    hit = 1; exp_d = 0;
    case (a)
      'hD034: exp_d = 'hE0 + m_sys;
      'hD02E: exp_d = 'hD0 + m_txt;
      'hDFFE: exp_d = 'h4A;
      'hDFFF: exp_d = 'hCD;
      default: hit = 0;
    endcase
    @(negedge clk);
    acc_valid = 1'b1; acc_rd = rd; acc_addr = a[15:0];
    #1;
    check(req, "ovr_en", int'(ovr_en), int'(exam && rd && setup && hit));
    if (exam && rd && setup && hit) check(req, "ovr_data", int'(ovr_data), exp_d);
    // model update
    if (exam) begin
      if (setup) begin
        if ((a >> 4) == 'hCEF) m_sys = a & 'hF;
        else if ((a >> 4) == 'hCFD) m_txt = a & 'hF;
      end else if (a == seq_q[m_step]) begin
        if (m_step == seq_q.size() - 1) begin m_sys = 0; m_step = 0; end
        else m_step++;
      end else m_step = 0;
    end
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check_banks(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_addr = 16'hCAFE;
      #1 check(req, "idle ovr_en", int'(ovr_en), 0);
      @(posedge clk); #1;
      check_banks(req);
    end
  endtask

  task automatic unlock(input string req);
    access('hCACA, 1, req); access('hCACA, 0, req); access('hCAFE, 1, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_banks("R1");
    check("R1", "ovr_en", int'(ovr_en), 0);
    // starts in setup mode: read-backs
    access('hD034, 1, "R8"); access('hD02E, 1, "R8");
    access('hDFFE, 1, "R9"); access('hDFFF, 1, "R9");
    access('hDFFE, 0, "R10");
    access('hCFD3, 0, "R7");   // text bank by write
    access('hD02E, 1, "R8");
    access('hC07F, 1, "R2");
    access('hCEF5, 0, "R6");   // leave setup by write
    access('hD034, 1, "R10");  // no override outside setup
    access('hCFD9, 1, "R7");   // ignored outside setup
    access('hCEF1, 1, "R6");   // ignored outside setup
    unlock("R3");
    access('hD034, 1, "R8");
    access('hCFD7, 1, "R7"); access('hD02E, 1, "R8");
    access('hCEFA, 1, "R6");
    // three CACA then CAFE: no unlock
    access('hCACA, 1, "R4"); access('hCACA, 1, "R4");
    access('hCACA, 1, "R4"); access('hCAFE, 1, "R4");
    // foreign examined address mid-sequence
    access('hCACA, 1, "R4"); access('hD000, 1, "R4");
    access('hCACA, 1, "R4"); access('hCAFE, 1, "R4");
    // low address mid-sequence does not break it
    access('hCACA, 1, "R2"); access('hC000, 0, "R2");
    access('hCACA, 1, "R2"); access('hCAFE, 1, "R2");
    // idle gaps between steps
    access('hCEF2, 1, "R6");
    access('hCACA, 1, "R11"); idle(3, "R11");
    access('hCACA, 0, "R11"); idle(2, "R11");
    access('hCAFE, 0, "R11");
    // tracker frozen in setup mode
    access('hCACA, 1, "R5"); access('hCACA, 1, "R5");
    access('hCEF3, 1, "R5"); access('hCAFE, 1, "R5");
    access('hD034, 1, "R5");
    // reset again mid-use
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    m_sys = 0; m_txt = 0; m_step = 0;
    check_banks("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule